// File: doc/BRIEF.md
# Multi-Mode Serial Receiver

This block is the receive half of a serial port. A two-bit mode input picks one of four framings. Mode 00 is a clocked shift register: the block drives its own shift clock and samples the data line once per bit. Mode 01 receives asynchronous frames that carry 8 data bits. Modes 10 and 11 receive asynchronous frames that carry 9 data bits. Mode 10 runs at a fixed rate derived from the system clock. Modes 01 and 11 take their rate from an external 16x oversampling tick.

Each completed frame either commits or is discarded. A committed frame loads the data byte and the extra-bit register and raises a receive flag. That flag stays set until software clears it. A multiprocessor gate can hold back commits: in the 9-bit modes it drops frames whose ninth bit is 0, which lets a node ignore data traffic until its address frame arrives. In the 8-bit mode the same gate drops frames whose stop bit is bad. Framing errors and overruns are kept as separate sticky status flags.

Top module: `sio_rx`

## Requirements
- R1: After reset, rx_data, rx_bit9, rx_flag, frame_err and overrun are all 0, and sclk_out is 1.
- R2: Mode 00 starts a reception when rx_en is 1, rx_flag is 0 and the block is idle. Each of the 8 bit periods lasts M0_DIV clocks. sclk_out is low for the first half of each period and high for the second half. rxd is sampled on the last clock of each period, and bits arrive LSB first. rx_flag rises after the 8th sample, and rx_bit9 is left unchanged.
- R3: In the asynchronous modes, a falling edge on rxd while idle begins a start bit. That start bit is checked again OVS/2 ticks later. Data bits are then sampled every OVS ticks, LSB first: 8 bits in mode 01 and 9 bits in modes 10 and 11. The stop bit is sampled last, and the frame is decided at that sample.
- R4: In modes 01 and 11 the oversampling tick is baud_tick. In mode 10 the block makes its own tick once every M2_DIV clocks, so one bit lasts OVS*M2_DIV clocks.
- R5: If rxd is high again when the start bit is re-checked, the start is treated as a glitch. The block returns to idle, and rx_flag and rx_data do not change.
- R6: In modes 10 and 11 with mp_gate set to 1, a frame whose ninth bit is 0 is discarded: rx_flag, rx_data and rx_bit9 keep their values. A frame whose ninth bit is 1 commits.
- R7: In mode 01 with mp_gate set to 1, a frame whose stop bit is 0 is discarded. With mp_gate set to 0, that frame commits.
- R8: On a commit, rx_bit9 takes the ninth data bit in modes 10 and 11 and the sampled stop bit in mode 01.
- R9: In the asynchronous modes, a stop bit sampled as 0 sets frame_err, whether or not the frame commits. frame_err then stays set.
- R10: rx_flag is set by a commit and stays 1 until flag_clr is pulsed.
- R11: A commit while rx_flag is still 1 sets the sticky overrun flag and overwrites rx_data.
- R12: While rx_en is 0 no reception starts. Dropping rx_en in the middle of a frame abandons that frame, and no flag is raised.
- R13: A pulse on err_clr clears both frame_err and overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Framing select (00 shift, 01 8-bit, 10 9-bit fixed rate, 11 9-bit variable rate) |
| rx_en | input | 1 | Receive enable |
| mp_gate | input | 1 | Multiprocessor commit gate |
| baud_tick | input | 1 | 16x oversampling tick for modes 01 and 11 |
| rxd | input | 1 | Serial data line |
| flag_clr | input | 1 | Clears rx_flag |
| err_clr | input | 1 | Clears frame_err and overrun |
| rx_data | output | 8 | Last committed data byte |
| rx_bit9 | output | 1 | Ninth data bit or stop bit of the last commit |
| rx_flag | output | 1 | Sticky receive flag |
| frame_err | output | 1 | Sticky framing error |
| overrun | output | 1 | Sticky overrun |
| sclk_out | output | 1 | Shift clock driven in mode 00 |

## Verification
The bench sweeps every byte value in mode 01, and strided sets of values in modes 00, 10 and 11. Its expected words are built bit by bit, so a design that shifts MSB first, or that drops or duplicates a sample point, returns the wrong byte.

Mode 10 is timed at 32 clocks per bit. A design that used baud_tick in that mode would sample twice per bit and return garbage.

Address filtering is tested with both values of the ninth bit, and the 8-bit mode is tested with bad stop bits under both gate settings. A design that gated on the wrong bit, or that forgot to record the framing error on a discarded frame, shows up there.

Several further cases are driven:
- a short low pulse on the line, which must produce no commit;
- a frame sent while receive is disabled;
- a frame cut off when receive drops partway through;
- two frames with no clear in between, which must raise overrun.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

  typedef enum logic [1:0] {
    MD_SHIFT  = 2'b00,
    MD_UART8  = 2'b01,
    MD_UART9F = 2'b10,
    MD_UART9V = 2'b11
  } sio_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SHIFT, ST_START, ST_DATA, ST_STOP
  } rx_state_e;

  // number of data bits carried by an asynchronous frame
  function automatic logic [3:0] frame_bits(input logic [1:0] m);
    return m[1] ? 4'd9 : 4'd8;
  endfunction

  // byte position inside the 9-bit shift word (8-bit frames end one bit higher)
  function automatic logic [7:0] pick_byte(input logic [8:0] w, input logic [1:0] m);
    return m[1] ? w[7:0] : w[8:1];
  endfunction

  // commit decision under the multiprocessor gate
  function automatic logic take_frame(input logic [1:0] m, input logic mp,
                                      input logic d8, input logic stop_b);
    case (m)
      MD_SHIFT: return 1'b1;
      MD_UART8: return !mp || stop_b;
      default:  return !mp || d8;
    endcase
  endfunction

  // value loaded into the extra-bit register on a commit
  function automatic logic pick_bit9(input logic [1:0] m, input logic d8,
                                     input logic stop_b, input logic old);
    case (m)
      MD_SHIFT: return old;
      MD_UART8: return stop_b;
      default:  return d8;
    endcase
  endfunction

endpackage

// File: rtl/sio_tick_gen.sv
module sio_tick_gen
  import sio_rx_pkg::*;
#(
  parameter int M2_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       baud_tick,
  output logic       tick
);
  localparam int DW = (M2_DIV > 1) ? $clog2(M2_DIV) : 1;

  logic [DW-1:0] div_q;
  logic          div_hit;

  assign div_hit = (div_q == DW'(M2_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_hit ? '0 : div_q + 1'b1;
  end

  assign tick = (mode == MD_UART9F) ? div_hit : baud_tick;
endmodule

// File: rtl/sio_rx_fsm.sv
module sio_rx_fsm
  import sio_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int M0_DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       rx_en,
  input  logic       flag_busy,
  input  logic       tick,
  input  logic       rxd,
  output logic       busy,
  output logic       sclk_out,
  output logic       frame_done,
  output logic       stop_val,
  output logic [8:0] word
);
  localparam int CMAX    = (OVS > M0_DIV) ? OVS : M0_DIV;
  localparam int CW      = $clog2(CMAX);
  localparam int HALF_OV = OVS / 2;
  localparam int HALF_M0 = M0_DIV / 2;

  rx_state_e     state;
  logic [CW-1:0] ph;
  logic [3:0]    idx;
  logic [8:0]    sh;
  logic          rxd_q;
  logic          sample0, samp_mid, samp_half;
  logic [8:0]    fin;

  assign fin       = {rxd, sh[8:1]};
  assign sample0   = (state == ST_SHIFT) && (ph == CW'(M0_DIV - 1));
  assign samp_mid  = tick && (ph == CW'(OVS - 1));
  assign samp_half = tick && (ph == CW'(HALF_OV - 1));

  assign frame_done = (sample0 && idx == 4'd7) || (state == ST_STOP && samp_mid);
  assign stop_val   = rxd;
  assign word       = (state == ST_SHIFT) ? fin : sh;
  assign busy       = (state != ST_IDLE);
  assign sclk_out   = !((state == ST_SHIFT) && (ph < CW'(HALF_M0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ph    <= '0;
      idx   <= '0;
      sh    <= '0;
      rxd_q <= 1'b1;
    end else begin
      rxd_q <= rxd;
      if (!rx_en) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            ph  <= '0;
            idx <= '0;
            if (mode == MD_SHIFT) begin
              if (!flag_busy) state <= ST_SHIFT;
            end else if (rxd_q && !rxd) begin
              state <= ST_START;
            end
          end
          ST_SHIFT: begin
            if (sample0) begin
              sh  <= fin;
              ph  <= '0;
              idx <= idx + 4'd1;
              if (idx == 4'd7) state <= ST_IDLE;
            end else begin
              ph <= ph + 1'b1;
            end
          end
          ST_START: if (tick) begin
            if (samp_half) begin
              ph    <= '0;
              idx   <= '0;
              state <= rxd ? ST_IDLE : ST_DATA;
            end else begin
              ph <= ph + 1'b1;
            end
          end
          ST_DATA: if (tick) begin
            if (samp_mid) begin
              sh  <= fin;
              ph  <= '0;
              idx <= idx + 4'd1;
              if (idx == frame_bits(mode) - 4'd1) state <= ST_STOP;
            end else begin
              ph <= ph + 1'b1;
            end
          end
          ST_STOP: if (tick) begin
            if (samp_mid) state <= ST_IDLE;
            else          ph    <= ph + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sio_rx_flags.sv
module sio_rx_flags
  import sio_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       mp_gate,
  input  logic       frame_done,
  input  logic [8:0] word,
  input  logic       stop_val,
  input  logic       flag_clr,
  input  logic       err_clr,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       rx_flag,
  output logic       frame_err,
  output logic       overrun,
  output logic       frame_accept
);
  logic bad_stop;

  assign frame_accept = frame_done && take_frame(mode, mp_gate, word[8], stop_val);
  assign bad_stop     = frame_done && (mode != MD_SHIFT) && !stop_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_bit9   <= 1'b0;
      rx_flag   <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (frame_accept) begin
        rx_data <= pick_byte(word, mode);
        rx_bit9 <= pick_bit9(mode, word[8], stop_val, rx_bit9);
      end
      rx_flag   <= frame_accept | (rx_flag & ~flag_clr);
      frame_err <= bad_stop | (frame_err & ~err_clr);
      overrun   <= (frame_accept & rx_flag) | (overrun & ~err_clr);
    end
  end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int M0_DIV = 16,
  parameter int M2_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       rx_en,
  input  logic       mp_gate,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic       flag_clr,
  input  logic       err_clr,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       rx_flag,
  output logic       frame_err,
  output logic       overrun,
  output logic       sclk_out
);
  logic       tick;
  logic       busy;
  logic       frame_done;
  logic       stop_val;
  logic [8:0] word9;
  logic       frame_accept;

  sio_tick_gen #(.M2_DIV(M2_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .baud_tick(baud_tick), .tick(tick)
  );

  sio_rx_fsm #(.OVS(OVS), .M0_DIV(M0_DIV)) fsm_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rx_en(rx_en), .flag_busy(rx_flag),
    .tick(tick), .rxd(rxd), .busy(busy), .sclk_out(sclk_out),
    .frame_done(frame_done), .stop_val(stop_val), .word(word9)
  );

  sio_rx_flags flags_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .mp_gate(mp_gate),
    .frame_done(frame_done), .word(word9), .stop_val(stop_val),
    .flag_clr(flag_clr), .err_clr(err_clr), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_flag(rx_flag), .frame_err(frame_err),
    .overrun(overrun), .frame_accept(frame_accept)
  );
endmodule

// File: rtl/sio_rx_chk.sv
module sio_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       rx_en,
  input logic       mp_gate,
  input logic       rx_flag,
  input logic       frame_err,
  input logic       overrun,
  input logic       sclk_out,
  input logic       busy,
  input logic       frame_done,
  input logic       stop_val,
  input logic [8:0] word9,
  input logic       frame_accept
);
  a_r10_flag_rise_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> $past(frame_accept));

  a_r6_ninth_zero_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && mode[1] && mp_gate && !word9[8]) |-> !frame_accept);

  a_r7_bad_stop_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && mode == 2'b01 && mp_gate && !stop_val) |-> !frame_accept);

  a_r9_fe_needs_bad_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> $past(frame_done && !stop_val && mode != 2'b00));

  a_r11_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_flag && frame_accept));

  a_r12_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !busy);

  a_r2_sclk_high_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_out);
endmodule

bind sio_rx sio_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .rx_en(rx_en), .mp_gate(mp_gate),
  .rx_flag(rx_flag), .frame_err(frame_err), .overrun(overrun),
  .sclk_out(sclk_out), .busy(busy), .frame_done(frame_done),
  .stop_val(stop_val), .word9(word9), .frame_accept(frame_accept)
);

// File: tb/sio_rx_tb.sv
module sio_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b01;
  logic       rx_en = 1'b0;
  logic       mp_gate = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       flag_clr = 1'b0;
  logic       err_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_flag, frame_err, overrun, sclk_out;

  int checks = 0;
  int errors = 0;
  int bt_per = 1;
  int bt_cnt = 0;
  logic [7:0] last_data = 8'h00;
  logic       last_b9 = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (bt_cnt >= bt_per - 1) begin bt_cnt <= 0; baud_tick <= 1'b1; end
    else begin bt_cnt <= bt_cnt + 1; baud_tick <= 1'b0; end
  end

  sio_rx dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rx_en(rx_en), .mp_gate(mp_gate),
    .baud_tick(baud_tick), .rxd(rxd), .flag_clr(flag_clr), .err_clr(err_clr),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_flag(rx_flag),
    .frame_err(frame_err), .overrun(overrun), .sclk_out(sclk_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_flag_clr();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic pulse_err_clr();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
  endtask

  // one asynchronous frame; bit length follows the mode's tick rate
  task automatic send_async(input logic [1:0] md, input logic [8:0] val, input logic stopb);
    int bc;
    int nb;
    bc = (md == 2'b10) ? 32 : 16 * bt_per;
    nb = md[1] ? 9 : 8;
    @(negedge clk) rxd = 1'b0;
    wait_clk(bc);
    for (int i = 0; i < nb; i++) begin
      rxd = val[i];
      wait_clk(bc);
    end
    rxd = stopb;
    wait_clk(bc);
    rxd = 1'b1;
    wait_clk(bc);
  endtask

  // commit path check with model-side bookkeeping
  task automatic expect_commit(input string tag, input logic [7:0] d, input logic b9);
    chk({tag, " flag"}, 16'(rx_flag), 16'd1);
    chk({tag, " data"}, 16'(rx_data), 16'(d));
    chk({tag, " bit9"}, 16'(rx_bit9), 16'(b9));
    last_data = d;
    last_b9   = b9;
  endtask

  task automatic expect_drop(input string tag);
    chk({tag, " flag"}, 16'(rx_flag), 16'd0);
    chk({tag, " data"}, 16'(rx_data), 16'(last_data));
    chk({tag, " bit9"}, 16'(rx_bit9), 16'(last_b9));
  endtask

  task automatic recv_sync(input logic [7:0] v);
    mode = 2'b00;
    @(negedge clk) rx_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge sclk_out);
      #1 rxd = v[i];
    end
    wait_clk(30);
    rx_en = 1'b0;
    expect_commit("R2 mode0", v, last_b9);
    pulse_flag_clr();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // R1 reset state
    chk("R1 data", 16'(rx_data), 16'd0);
    chk("R1 bit9", 16'(rx_bit9), 16'd0);
    chk("R1 flag", 16'(rx_flag), 16'd0);
    chk("R1 fe", 16'(frame_err), 16'd0);
    chk("R1 ovr", 16'(overrun), 16'd0);
    chk("R1 sclk", 16'(sclk_out), 16'd1);

    // R12: disabled receiver ignores a whole frame
    mode = 2'b01; rx_en = 1'b0;
    send_async(2'b01, 9'h0A5, 1'b1);
    expect_drop("R12 disabled");

    // R3 R8: full byte sweep in 8-bit mode
    rx_en = 1'b1;
    for (int v = 0; v < 256; v++) begin
      send_async(2'b01, 9'(v), 1'b1);
      expect_commit("R3 mode1", 8'(v), 1'b1);
      pulse_flag_clr();
    end

    // R4: mode 1 follows a slower baud_tick
    bt_per = 3;
    for (int v = 1; v < 256; v += 67) begin
      send_async(2'b01, 9'(v), 1'b1);
      expect_commit("R4 slow tick", 8'(v), 1'b1);
      pulse_flag_clr();
    end
    bt_per = 1;

    // R4 R8: mode 2 at its internal rate, ninth bit captured
    mode = 2'b10;
    for (int v = 0; v < 256; v += 17) begin
      logic d8;
      d8 = v[4];
      send_async(2'b10, {d8, 8'(v)}, 1'b1);
      expect_commit("R4 R8 mode2", 8'(v), d8);
      pulse_flag_clr();
    end

    // R6: mode 3 address gate
    mode = 2'b11; mp_gate = 1'b1;
    for (int v = 3; v < 256; v += 7) begin
      send_async(2'b11, {1'b0, 8'(v)}, 1'b1);
      expect_drop("R6 d8=0");
      send_async(2'b11, {1'b1, 8'(v ^ 8'h5A)}, 1'b1);
      expect_commit("R6 d8=1", 8'(v ^ 8'h5A), 1'b1);
      pulse_flag_clr();
    end

    // R7 R9: bad stop in mode 1 with gate set
    mode = 2'b01;
    send_async(2'b01, 9'h03C, 1'b0);
    expect_drop("R7 gated stop");
    chk("R9 fe on dropped", 16'(frame_err), 16'd1);
    // R13 clear
    pulse_err_clr();
    chk("R13 fe clr", 16'(frame_err), 16'd0);
    // R7 gate set, good stop commits
    send_async(2'b01, 9'h0C3, 1'b1);
    expect_commit("R7 good stop", 8'hC3, 1'b1);
    pulse_flag_clr();
    // R7 R8 R9 gate clear, bad stop commits with bit9=0
    mp_gate = 1'b0;
    send_async(2'b01, 9'h07E, 1'b0);
    expect_commit("R7 R8 ungated", 8'h7E, 1'b0);
    chk("R9 fe sticky", 16'(frame_err), 16'd1);
    pulse_flag_clr();
    wait_clk(100);
    chk("R9 fe held", 16'(frame_err), 16'd1);
    pulse_err_clr();

    // R5: short low glitch
    @(negedge clk) rxd = 1'b0;
    wait_clk(3);
    rxd = 1'b1;
    wait_clk(200);
    expect_drop("R5 glitch");

    // R12: abort mid-frame
    fork
      send_async(2'b01, 9'h055, 1'b1);
      begin wait_clk(60); rx_en = 1'b0; end
    join
    rx_en = 1'b1;
    wait_clk(40);
    expect_drop("R12 abort");

    // R10 R11: two commits without clear
    send_async(2'b01, 9'h011, 1'b1);
    wait_clk(100);
    chk("R10 flag held", 16'(rx_flag), 16'd1);
    chk("R11 no ovr yet", 16'(overrun), 16'd0);
    send_async(2'b01, 9'h022, 1'b1);
    expect_commit("R11 overwrite", 8'h22, 1'b1);
    chk("R11 ovr", 16'(overrun), 16'd1);
    pulse_flag_clr();
    chk("R10 flag clr", 16'(rx_flag), 16'd0);
    chk("R11 ovr sticky", 16'(overrun), 16'd1);
    pulse_err_clr();
    chk("R13 ovr clr", 16'(overrun), 16'd0);

    // R2: shift-register mode sweep
    rx_en = 1'b0;
    for (int v = 0; v < 256; v += 5) recv_sync(8'(v));
    chk("R2 sclk idle", 16'(sclk_out), 16'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule